// File: doc/BRIEF.md
# Watchdog and Sleep Wake Controller

This block holds the power-down and watchdog logic of a small 8-bit microcontroller. A free-running watchdog base counter counts core clocks while the configuration enable is set. An 8-bit postscaler either stretches the watchdog period or divides the general-purpose timer's clock source. The option bit `psa_i` selects which of the two uses it. A three-bit select picks one of eight postscaler taps, so the division ratio is 1:1 up to 1:128.

The core pulses `sleep_i` when it executes its power-down instruction, and `clrwdt_i` when it services the watchdog. The block keeps two status flags: a power-down flag and a timeout flag. Software reads them after a reset or wake to learn why the part left sleep.

While asleep, the oscillator-off output stays high. The part leaves sleep in one of three ways:
- A watchdog timeout or an enabled, wake-capable interrupt produces a one-cycle wake pulse, and the program resumes.
- The external reset pin always produces a device-reset request.
- A watchdog timeout while awake also produces a device-reset request.

Top module: `wdt_sleep_ctrl`

## Requirements
- R1: After the asynchronous power-on reset (`por_n` low), the power-down and timeout flags read 1, oscillator-off reads 0, and the wake and device-reset outputs read 0.
- R2: A sleep strobe while awake sets the part asleep on the next clock. The power-down flag reads 0, the timeout flag reads 1, and oscillator-off reads 1. The base counter restarts from zero. When the postscaler serves the watchdog, the postscaler also restarts from zero.
- R3: A clear-watchdog strobe while awake has three effects. It restarts the base counter. It restarts the postscaler when the postscaler serves the watchdog. It sets both flags to 1. A sleep strobe in the same cycle takes precedence.
- R4: With `psa_i`=1, the first timeout comes 2^BASE_W × 2^`ps_i` clocks after a restart. With `psa_i`=0, it comes 2^BASE_W clocks after a restart, whatever the value of `ps_i`.
- R5: With `psa_i`=0, `tmr_tick_o` passes one of every 2^`ps_i` source ticks. With `psa_i`=1, `tmr_tick_o` equals `tmr_src_tick_i`.
- R6: A timeout while awake raises `dev_rst_o` for exactly one cycle and clears the timeout flag. The power-down flag keeps its value.
- R7: A timeout while asleep clears the timeout flag and ends sleep with a wake pulse. It raises no device-reset request.
- R8: While asleep, an interrupt wakes the part only if three conditions hold: its request bit is set, its enable bit is set, and its bit in WAKE_MASK is 1. Such a wake leaves both flags unchanged.
- R9: `wake_o` is high for one clock only. In that same cycle `osc_off_o` drops from 1 to 0.
- R10: The cycle after `mclr_n` is sampled low, `dev_rst_o` reads 1 and `osc_off_o` reads 0. No wake pulse is produced. The flags keep their values.
- R11: With `wdt_en_i`=0 the watchdog never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and control clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| mclr_n | input | 1 | External reset pin, active low |
| sleep_i | input | 1 | Power-down instruction strobe |
| clrwdt_i | input | 1 | Clear-watchdog strobe |
| wdt_en_i | input | 1 | Configuration enable for the watchdog |
| psa_i | input | 1 | Postscaler assignment: 1 watchdog, 0 timer |
| ps_i | input | PS_W | Postscaler tap select |
| tmr_src_tick_i | input | 1 | Timer clock-source tick |
| irq_req_i | input | N_IRQ | Interrupt requests |
| irq_en_i | input | N_IRQ | Interrupt enables |
| stat_pd_o | output | 1 | Power-down flag |
| stat_to_o | output | 1 | Timeout flag (0 after a timeout) |
| dev_rst_o | output | 1 | Device-reset request |
| wake_o | output | 1 | One-cycle wake pulse |
| osc_off_o | output | 1 | Oscillator driver off |
| tmr_tick_o | output | 1 | Postscaled tick to the timer |

## Verification
The bench builds the block with BASE_W=4, N_IRQ=3 and WAKE_MASK=3'b011. The short base period of 16 clocks makes each watchdog period cheap to measure, from 1:1 up to 1:32. It also keeps both the awake-reset timeout and the asleep-wake timeout within a few hundred cycles. The third interrupt source has its WAKE_MASK bit at 0. It stands in for a peripheral that cannot wake the part, so the bench can show that a source which is both requested and enabled still leaves the part asleep.

// File: rtl/wdt_sleep_ctrl.sv
module wdt_sleep_ctrl #(
  parameter int BASE_W = 10,
  parameter int PS_W = 3,
  parameter int N_IRQ = 4,
  parameter logic [N_IRQ-1:0] WAKE_MASK = '1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mclr_n,
  input  logic             sleep_i,
  input  logic             clrwdt_i,
  input  logic             wdt_en_i,
  input  logic             psa_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             tmr_src_tick_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  output logic             stat_pd_o,
  output logic             stat_to_o,
  output logic             dev_rst_o,
  output logic             wake_o,
  output logic             osc_off_o,
  output logic             tmr_tick_o
);
  localparam int POST_W = 1 << PS_W;

  logic [BASE_W-1:0] base_q;
  logic [POST_W-1:0] post_q;
  logic asleep_q, pd_q, to_q, wake_q, rst_q;

  wire [POST_W-1:0] tap_mask = (POST_W'(1) << ps_i) - POST_W'(1);
  wire post_hit    = (post_q & tap_mask) == tap_mask;
  wire base_tc     = wdt_en_i && (&base_q);
  wire wdt_timeout = base_tc && (!psa_i || post_hit);
  wire do_sleep    = !asleep_q && sleep_i;
  wire do_clr      = !asleep_q && clrwdt_i && !sleep_i;
  wire restart     = do_sleep || do_clr;
  wire irq_wake    = asleep_q && (|(irq_req_i & irq_en_i & WAKE_MASK));
  wire post_step   = psa_i ? base_tc : tmr_src_tick_i;

  assign tmr_tick_o = psa_i ? tmr_src_tick_i : (tmr_src_tick_i && post_hit);
  assign stat_pd_o  = pd_q;
  assign stat_to_o  = to_q;
  assign dev_rst_o  = rst_q;
  assign wake_o     = wake_q;
  assign osc_off_o  = asleep_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) base_q <= '0;
    else if (!mclr_n || restart || !wdt_en_i) base_q <= '0;
    else base_q <= base_q + BASE_W'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) post_q <= '0;
    else if (!mclr_n || (psa_i && (restart || wdt_timeout))) post_q <= '0;
    else if (post_step) post_q <= post_q + POST_W'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pd_q <= 1'b1; to_q <= 1'b1; asleep_q <= 1'b0;
      wake_q <= 1'b0; rst_q <= 1'b0;
    end else if (!mclr_n) begin
      asleep_q <= 1'b0; wake_q <= 1'b0; rst_q <= 1'b1;
    end else begin
      wake_q <= 1'b0;
      rst_q  <= 1'b0;
      if (do_sleep) begin
        asleep_q <= 1'b1; pd_q <= 1'b0; to_q <= 1'b1;
      end else if (do_clr) begin
        pd_q <= 1'b1; to_q <= 1'b1;
      end else if (wdt_timeout) begin
        to_q <= 1'b0;
        if (asleep_q) begin
          asleep_q <= 1'b0; wake_q <= 1'b1;
        end else begin
          rst_q <= 1'b1;
        end
      end else if (irq_wake) begin
        asleep_q <= 1'b0; wake_q <= 1'b1;
      end
    end
  end

  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!por_n)
    (sleep_i && !osc_off_o && mclr_n) |=> (!stat_pd_o && stat_to_o && osc_off_o));

  a_r2_pd_falls_on_sleep: assert property (@(posedge clk) disable iff (!por_n)
    $fell(stat_pd_o) |-> $past(sleep_i));

  a_r6_wdt_reset_awake: assert property (@(posedge clk) disable iff (!por_n)
    (dev_rst_o && $past(mclr_n)) |-> (!stat_to_o && !$past(osc_off_o)));

  a_r6_reset_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
    (dev_rst_o && mclr_n) |=> !dev_rst_o);

  a_r8_wake_source: assert property (@(posedge clk) disable iff (!por_n)
    (wake_o && stat_to_o) |-> $past(|(irq_req_i & irq_en_i & WAKE_MASK)));

  a_r9_wake_single: assert property (@(posedge clk) disable iff (!por_n)
    wake_o |=> !wake_o);

  a_r9_wake_osc: assert property (@(posedge clk) disable iff (!por_n)
    wake_o |-> (!osc_off_o && $past(osc_off_o)));

  a_r10_pin_reset: assert property (@(posedge clk) disable iff (!por_n)
    !mclr_n |=> (dev_rst_o && !osc_off_o && !wake_o));

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!por_n)
    (!wdt_en_i && !$past(wdt_en_i) && mclr_n && !osc_off_o) |=> !dev_rst_o);
endmodule

// File: tb/test_wdt_sleep_ctrl.sv
module test_wdt_sleep_ctrl;
  logic clk = 1'b0;
  logic por_n = 1'b0, mclr_n = 1'b1, sleep_i = 1'b0, clrwdt_i = 1'b0;
  logic wdt_en_i = 1'b0, psa_i = 1'b1, tmr_src_tick_i = 1'b0;
  logic [2:0] ps_i = 3'd0, irq_req_i = 3'b000, irq_en_i = 3'b000;
  logic stat_pd_o, stat_to_o, dev_rst_o, wake_o, osc_off_o, tmr_tick_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wdt_sleep_ctrl #(.BASE_W(4), .PS_W(3), .N_IRQ(3), .WAKE_MASK(3'b011)) i_wdt_sleep_ctrl (
    .clk(clk), .por_n(por_n), .mclr_n(mclr_n), .sleep_i(sleep_i), .clrwdt_i(clrwdt_i),
    .wdt_en_i(wdt_en_i), .psa_i(psa_i), .ps_i(ps_i), .tmr_src_tick_i(tmr_src_tick_i),
    .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .stat_pd_o(stat_pd_o), .stat_to_o(stat_to_o),
    .dev_rst_o(dev_rst_o), .wake_o(wake_o), .osc_off_o(osc_off_o), .tmr_tick_o(tmr_tick_o));

  localparam int NV = 6;
  localparam int VEC_PSA [NV] = '{1, 1, 1, 1, 0, 0};
  localparam int VEC_PS  [NV] = '{0, 1, 2, 5, 0, 3};
  localparam int VEC_CYC [NV] = '{16, 32, 64, 512, 16, 16};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe_sleep();
    @(negedge clk); sleep_i = 1'b1;
    @(negedge clk); sleep_i = 1'b0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, hits;
    #10 por_n = 1'b1;
    @(negedge clk);
    chk("R1 pd", stat_pd_o, 1); chk("R1 to", stat_to_o, 1);
    chk("R1 osc_off", osc_off_o, 0); chk("R1 wake", wake_o, 0); chk("R1 rst", dev_rst_o, 0);

    // R4/R6: watchdog period table, awake timeouts
    wdt_en_i = 1'b1;
    for (int v = 0; v < NV; v++) begin
      psa_i = VEC_PSA[v][0]; ps_i = VEC_PS[v][2:0];
      clrwdt_i = 1'b1;
      @(negedge clk); clrwdt_i = 1'b0;
      chk("R3 to after clear", stat_to_o, 1);
      k = 0;
      while (k < 4000) begin
        @(negedge clk); k++;
        if (dev_rst_o) break;
      end
      chk("R4 period", k, VEC_CYC[v]);
      chk("R6 to cleared", stat_to_o, 0);
      chk("R6 pd kept", stat_pd_o, 1);
      @(negedge clk);
      chk("R6 one cycle", dev_rst_o, 0);
    end

    // R7: timeout during sleep wakes, ratio 1:2
    psa_i = 1'b1; ps_i = 3'd1;
    strobe_sleep();
    chk("R2 pd", stat_pd_o, 0); chk("R2 to", stat_to_o, 1); chk("R2 osc_off", osc_off_o, 1);
    hits = 0; k = 0;
    while (k < 4000) begin
      @(negedge clk); k++;
      if (dev_rst_o) hits++;
      if (wake_o) break;
    end
    chk("R2 R7 wake time", k, 32);
    chk("R7 to", stat_to_o, 0); chk("R7 no rst", hits, 0);
    chk("R9 osc_off", osc_off_o, 0);
    @(negedge clk);
    chk("R9 wake width", wake_o, 0);

    // R8: interrupt wake
    wdt_en_i = 1'b0;
    strobe_sleep();
    irq_en_i = 3'b001; irq_req_i = 3'b010;
    repeat (4) @(negedge clk);
    chk("R8 disabled source", osc_off_o, 1);
    irq_en_i = 3'b100; irq_req_i = 3'b100;
    repeat (4) @(negedge clk);
    chk("R8 masked source", osc_off_o, 1);
    chk("R11 no timeout asleep", wake_o, 0);
    irq_en_i = 3'b001; irq_req_i = 3'b001;
    @(negedge clk);
    chk("R8 wake", wake_o, 1); chk("R9 osc drop", osc_off_o, 0);
    chk("R8 pd kept", stat_pd_o, 0); chk("R8 to kept", stat_to_o, 1);
    irq_req_i = 3'b000; irq_en_i = 3'b000;
    @(negedge clk);
    chk("R9 wake width irq", wake_o, 0);

    // R10: external pin during sleep
    strobe_sleep();
    mclr_n = 1'b0;
    @(negedge clk);
    chk("R10 rst", dev_rst_o, 1); chk("R10 osc", osc_off_o, 0); chk("R10 no wake", wake_o, 0);
    chk("R10 pd", stat_pd_o, 0); chk("R10 to", stat_to_o, 1);
    mclr_n = 1'b1;
    @(negedge clk);
    chk("R10 release", dev_rst_o, 0);

    // R3: clear sets pd
    clrwdt_i = 1'b1; @(negedge clk); clrwdt_i = 1'b0;
    chk("R3 pd set", stat_pd_o, 1);

    // R11: disabled watchdog never fires
    hits = 0;
    repeat (300) begin @(negedge clk); if (dev_rst_o) hits++; end
    chk("R11 no reset", hits, 0);

    // R5: timer path
    tmr_src_tick_i = 1'b1;
    for (int p = 0; p < 4; p++) begin
      psa_i = 1'b0; ps_i = 3'(p);
      hits = 0;
      repeat (64) begin @(negedge clk); if (tmr_tick_o) hits++; end
      chk("R5 timer division", hits, 64 >> p);
    end
    psa_i = 1'b1; ps_i = 3'd3;
    @(negedge clk); chk("R5 bypass high", tmr_tick_o, 1);
    tmr_src_tick_i = 1'b0;
    @(negedge clk); chk("R5 bypass low", tmr_tick_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule